// File: doc/BRIEF.md
# PIRQ Interrupt Line Router

This block merges eight level-sensitive PCI interrupt request inputs (PIRQ A to H) and one system-control interrupt (SCI) level into a 24-line global interrupt vector. Lines 0 to 15 feed a legacy interrupt controller, and lines 16 to 23 feed an I/O APIC. Each PIRQ has a route byte that gives a legacy IRQ number and a disable flag. A legacy line is asserted while any enabled PIRQ routed to it is high, so several PIRQs can share one line. On the APIC side each PIRQ has its own line, and the route bytes have no effect there.

The SCI is added to exactly one line. A 3-bit select field chooses that line, and the field encodes only five targets. Three of the targets are legacy lines and two are APIC lines. The unused codes leave the SCI disconnected. Software programs the route bytes and the select field through a byte-wide write port. The vector is registered, so every output changes one clock after its cause.

Top module: `pirq_irq_router`

## Requirements
- R1: While reset is active, and in the first cycle after it, `gsiOut` is all zeros. Reset sets every route byte to 0x80 (disabled) and the SCI select to 0.
- R2: A write with `wrEn` high stores `wrData` as follows. Addresses 0 to 3 hold the route bytes for PIRQ A to D. Addresses 4 to 7 hold the route bytes for PIRQ E to H. Address 8 holds the control byte, whose bits [2:0] are the SCI select. A write to any address from 9 to 15 changes nothing.
- R3: In a route byte, bits [3:0] give the legacy line and bit 7 is the disable flag. A PIRQ whose disable flag is 1 drives no legacy line.
- R4: Each legacy line 0 to 15 is the OR of all enabled PIRQs whose route byte selects that line.
- R5: APIC line 16+n follows PIRQ n for n = 0 to 7, whatever the route bytes hold.
- R6: The SCI select codes map to lines as follows: 0 to line 9, 1 to line 10, 2 to line 11, 4 to line 20, 5 to line 21. Codes 3, 6 and 7 route the SCI to no line.
- R7: The SCI level is OR-ed into its selected line together with any PIRQ that drives the same line.
- R8: If the SCI select changes while the SCI is high, the old line is released and the new line is asserted in the same output cycle.
- R9: A change on `pirqLevel`, on `sciLevel` or in a stored register appears on `gsiOut` at the first rising edge after it is sampled or written, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 8 | Register write data |
| pirqLevel | input | 8 | PIRQ A to H levels, with bit 0 as PIRQ A |
| sciLevel | input | 1 | SCI level |
| gsiOut | output | 24 | Registered global interrupt lines |

## Verification
The checker runs on every cycle and checks four things: the APIC lines follow their PIRQs, the whole vector is quiet when no source is high, the SCI alone lights at most one line, and the vector is cleared around reset. Which legacy line lights is decided by the programmed route bytes and the select code, so only the bench scenarios can show that mapping. Those scenarios cover shared lines, disabled PIRQs, reserved select codes, ignored addresses and the handover of the SCI between lines. The same holds for the one-cycle timing, which the bench checks by sampling both before and after the capturing edge.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int unsigned PIRQ_COUNT = 8;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic [PIRQ_COUNT-1:0] routeWe;
    logic ctrlWe;
    logic [DATA_W-1:0] data;
  } wrStrobe_t;

  typedef struct packed {
    logic valid;
    logic [4:0] line;
  } sciTarget_t;

  // Sparse select decode: legacy targets 9..11, APIC targets 20..21.
  function automatic sciTarget_t sciTargetOf(input logic [2:0] sel);
    sciTarget_t t;
    t.valid = 1'b1;
    case (sel)
      3'd0: t.line = 5'd9;
      3'd1: t.line = 5'd10;
      3'd2: t.line = 5'd11;
      3'd4: t.line = 5'd20;
      3'd5: t.line = 5'd21;
      default: begin
        t.valid = 1'b0;
        t.line = 5'd0;
      end
    endcase
    return t;
  endfunction
endpackage

// File: rtl/pirq_route_ctrl.sv
module pirq_route_ctrl
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = PIRQ_COUNT,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CTRL_ADDR = NUM_PIRQ
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output wrStrobe_t         strobe
);
  logic [NUM_PIRQ-1:0] routeHit;

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_dec
    assign routeHit[n] = wrEn && (wrAddr == ADDR_W'(n));
  end

  always_comb begin
    strobe.routeWe = routeHit;
    strobe.ctrlWe  = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));
    strobe.data    = wrData;
  end
endmodule

// File: rtl/pirq_route_dp.sv
module pirq_route_dp
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = PIRQ_COUNT,
  parameter int unsigned NUM_LEGACY = 16,
  parameter int unsigned SEL_W = 3,
  parameter logic [DATA_W-1:0] ROUTE_RESET = 8'h80,
  parameter logic [SEL_W-1:0] SEL_RESET = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  wrStrobe_t                    strobe,
  input  logic [NUM_PIRQ-1:0]          pirqLevel,
  input  logic                         sciLevel,
  output logic [NUM_LEGACY+NUM_PIRQ-1:0] gsiOut
);
  localparam int unsigned GSI_W  = NUM_LEGACY + NUM_PIRQ;
  localparam int unsigned IRQ_W  = $clog2(NUM_LEGACY);
  localparam int unsigned LINE_W = $clog2(GSI_W);
  localparam int unsigned DIS_BIT = DATA_W - 1;

  logic [DATA_W-1:0] routeReg [NUM_PIRQ];
  logic [SEL_W-1:0]  sciSel;
  logic [GSI_W-1:0]  nextGsi;
  sciTarget_t        sciTgt;

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_route
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) routeReg[n] <= ROUTE_RESET;
      else if (strobe.routeWe[n]) routeReg[n] <= strobe.data;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sciSel <= SEL_RESET;
    else if (strobe.ctrlWe) sciSel <= strobe.data[SEL_W-1:0];
  end

  assign sciTgt = sciTargetOf(sciSel);

  always_comb begin
    logic [LINE_W-1:0] idx;
    nextGsi = '0;
    for (int n = 0; n < NUM_PIRQ; n++) begin
      nextGsi[NUM_LEGACY+n] = pirqLevel[n];
      idx = LINE_W'(routeReg[n][IRQ_W-1:0]);
      if (!routeReg[n][DIS_BIT]) nextGsi[idx] = nextGsi[idx] | pirqLevel[n];
    end
    if (sciTgt.valid) begin
      idx = LINE_W'(sciTgt.line);
      nextGsi[idx] = nextGsi[idx] | sciLevel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gsiOut <= '0;
    else gsiOut <= nextGsi;
  end
endmodule

// File: rtl/pirq_irq_router.sv
module pirq_irq_router
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = PIRQ_COUNT,
  parameter int unsigned NUM_LEGACY = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned GSI_W = NUM_LEGACY + NUM_PIRQ
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_PIRQ-1:0] pirqLevel,
  input  logic              sciLevel,
  output logic [GSI_W-1:0]  gsiOut
);
  wrStrobe_t strobe;

  pirq_route_ctrl #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strobe(strobe)
  );

  pirq_route_dp #(.NUM_PIRQ(NUM_PIRQ), .NUM_LEGACY(NUM_LEGACY)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pirqLevel(pirqLevel), .sciLevel(sciLevel), .gsiOut(gsiOut)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int unsigned NUM_PIRQ = 8,
  parameter int unsigned NUM_LEGACY = 16,
  parameter int unsigned GSI_W = NUM_LEGACY + NUM_PIRQ
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PIRQ-1:0] pirqLevel,
  input logic                sciLevel,
  input logic [GSI_W-1:0]    gsiOut
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else pastValid <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> gsiOut == '0); // R1

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_apic
    AST_APIC_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && $past(pirqLevel[n])) |-> gsiOut[NUM_LEGACY+n]); // R5
  end

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(pirqLevel) == '0 && !$past(sciLevel)) |-> gsiOut == '0); // R4

  AST_SCI_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(pirqLevel) == '0) |-> $onehot0(gsiOut)); // R6
endmodule

bind pirq_irq_router pirq_router_chk #(.NUM_PIRQ(NUM_PIRQ), .NUM_LEGACY(NUM_LEGACY)) u_chk (
  .clk(clk), .rstN(rstN), .pirqLevel(pirqLevel), .sciLevel(sciLevel), .gsiOut(gsiOut)
);

// File: tb/sim_pirq_irq_router.sv
module sim_pirq_irq_router;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] pirqLevel = '0;
  logic sciLevel = 1'b0;
  logic [23:0] gsiOut;

  int checks = 0;
  int fails = 0;
  logic [7:0] routeM [8];
  logic [2:0] selM;

  always #4 clk = ~clk;

  pirq_irq_router u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pirqLevel(pirqLevel), .sciLevel(sciLevel), .gsiOut(gsiOut)
  );

  // stimulus table: {pirq[7:0], sci}
  localparam logic [8:0] VEC [12] = '{
    9'h000, 9'h001, 9'h002, 9'h004, 9'h006, 9'h010,
    9'h011, 9'h008, 9'h100, 9'h1FE, 9'h1FF, 9'h0AA
  };

  function automatic logic [23:0] model(input logic [7:0] p, input logic s);
    logic [23:0] g = '0;
    for (int n = 0; n < 8; n++) begin
      g[16+n] = p[n];
      if (!routeM[n][7]) g[routeM[n][3:0]] |= p[n];
    end
    case (selM)
      3'd0: g[9]  |= s;
      3'd1: g[10] |= s;
      3'd2: g[11] |= s;
      3'd4: g[20] |= s;
      3'd5: g[21] |= s;
      default: ;
    endcase
    return g;
  endfunction

  task automatic check(input string req, input logic [23:0] exp);
    checks++;
    if (gsiOut !== exp) begin
      fails++;
      $display("FAIL %s: gsiOut=%06h expected=%06h", req, gsiOut, exp);
    end
  endtask

  task automatic write(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    if (a < 4'd8) routeM[a[2:0]] = d;
    else if (a == 4'd8) selM = d[2:0];
  endtask

  task automatic apply(input logic [7:0] p, input logic s);
    pirqLevel = p; sciLevel = s;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: run hung");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 8; n++) routeM[n] = 8'h80;
    selM = 3'd0;
    pirqLevel = 8'hFF; sciLevel = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", 24'h0);
    rstN = 1'b1;
    #1 check("R1 first cycle after reset", 24'h0);
    @(posedge clk); @(negedge clk);
    // defaults: all routes disabled, SCI on line 9
    check("R1 defaults", 24'hFF0200);

    write(4'd0, 8'h05); write(4'd1, 8'h05); write(4'd2, 8'h0B); write(4'd3, 8'h83);
    write(4'd4, 8'h03); write(4'd5, 8'h0A); write(4'd6, 8'h00); write(4'd7, 8'h87);
    write(4'd8, 8'h02);

    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][8:1], VEC[i][0]);
      check("R3/R4/R5/R7 table", model(VEC[i][8:1], VEC[i][0]));
    end

    // ignored addresses
    apply(8'h0F, 1'b1);
    write(4'd9, 8'h01); write(4'd12, 8'h07); write(4'd15, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R2 ignored address", 24'h0F0820);

    // reserved select codes
    for (int c = 3; c < 8; c += 3) begin
      write(4'd8, 8'(c));
      apply(8'h00, 1'b1);
      check("R6 reserved code", 24'h0);
    end
    write(4'd8, 8'h01); apply(8'h00, 1'b1);
    check("R6 code 1", 24'h000400);

    // SCI on APIC line shared with PIRQ E
    write(4'd8, 8'h04); apply(8'h10, 1'b1);
    check("R7 shared APIC line", 24'h100008);
    apply(8'h00, 1'b1);
    check("R6 code 4", 24'h100000);

    // select change while SCI high
    write(4'd8, 8'h05);
    check("R8 before handover", 24'h100000);
    @(posedge clk); @(negedge clk);
    check("R8 handover", 24'h200000);

    // latency
    pirqLevel = 8'h40;
    #1 check("R9 no early change", 24'h200000);
    @(posedge clk); #1;
    check("R9 one cycle", model(8'h40, 1'b1));
    @(negedge clk);

    // disabled PIRQ re-enable
    write(4'd3, 8'h03); apply(8'h08, 1'b0);
    check("R3 re-enabled D", 24'h080008);
    write(4'd3, 8'hF3); apply(8'h08, 1'b0);
    check("R3 disable with extra bits", 24'h080000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule